// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block is a small grid of multiply-accumulate cells that computes one vector-by-matrix product per clock once its pipeline is full. A coefficient matrix is held stationary inside the cells. Each cycle, an input vector of signed activations may be offered. Element r of that vector enters grid row r, and the activations step one cell to the right on every clock. Partial sums start at zero above the top row and move down one cell per clock. The bottom row delivers one dot product per column.

The block skews the activation rows internally, delaying row r by r cycles, so a whole vector is offered in a single cycle. The column results are realigned internally as well, so all columns of one result appear together with a single valid flag. Coefficients are written one cell at a time through a strobe, a cell index and a value. The write travels through the grid on the same diagonal wavefront as the data, so cell (r,c) captures it r+c cycles after the strobe. Every vector accepted after a write sees the new value in every cell. Writes are refused while a computation is in flight, and also in the cycle a vector is offered.

The grid size and the data widths are parameters. Larger grids reuse the same cell.

Top module: `mac_grid`

## Requirements
- R1: A synchronous active-high reset clears every coefficient to zero. It also clears every pipeline register, every valid bit and the in-flight counter, so after reset `busy`, `out_valid` and `out_sum` read zero.
- R2: A write pulse on `wt_load` with `wt_sel` = r*COLS + c stores `wt_data` as the coefficient of cell (r,c), provided the write is accepted. Every vector offered in any later cycle, including the cycle right after the strobe, uses the new value.
- R3: The result for column c, carried on `out_sum[c*32 +: 32]`, equals the signed sum over rows r of `in_act[r*8 +: 8]` times the coefficient of cell (r,c). Activations and coefficients are 8-bit two's complement; sums are 32-bit two's complement.
- R4: A vector offered with `in_valid` high in cycle t produces `out_valid` high in cycle t+3 (ROWS+COLS-1) for exactly that one cycle.
- R5: Vectors offered in consecutive cycles produce results in consecutive cycles, in the same order, one per clock.
- R6: A write strobe is ignored when `busy` is high or when `in_valid` is high in the same cycle. The stored coefficients are then unchanged.
- R7: After a vector is offered in cycle t, `busy` is high in cycles t+1 and t+2 (ROWS+COLS-2 cycles). It falls in the cycle that vector's result appears, unless later vectors keep it high.
- R8: Coefficients are kept across any number of vectors and idle cycles until that cell is written again. A write to one cell leaves the others unchanged.
- R9: `out_valid` is high only for results of offered vectors. In every cycle with `out_valid` low, `out_sum` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wt_load | input | 1 | Coefficient write strobe |
| wt_sel | input | 2 | Target cell index, r*COLS + c |
| wt_data | input | 8 | Signed coefficient value |
| in_valid | input | 1 | Input vector present this cycle |
| in_act | input | 16 | Activation vector; row r at bits [r*8 +: 8] |
| busy | output | 1 | A vector is in flight; coefficient writes are refused |
| out_valid | output | 1 | `out_sum` carries a result |
| out_sum | output | 64 | Column results; column c at bits [c*32 +: 32] |

## Verification
The hardest case to reach is a vector that follows the last coefficient write with no gap. At that point the write is still travelling towards the far corner cell, and it arrives there in the same cycle as the vector's wavefront. The directed tasks create this by issuing the writes in both index orders and offering a vector in the very next cycle. Refused writes are reached by raising the strobe together with `in_valid`, and again while `busy` is still high in the middle of a stream. Later results then show whether any coefficient changed.

// File: rtl/mac_grid_pkg.sv
package mac_grid_pkg;

   // Bits needed to index n items (at least one bit).
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/mac_skew.sv
// Fixed-depth register delay line with synchronous clear.
module mac_skew #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mac_skew: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mac_skew: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage [DEPTH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      end else begin
         stage[0] <= d;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign q = stage[DEPTH-1];

endmodule

// File: rtl/mac_pe.sv
// One grid cell: a stationary coefficient and a registered multiply-add.
module mac_pe #(
   parameter int unsigned AW  = 8,
   parameter int unsigned WW  = 8,
   parameter int unsigned SW  = 32,
   parameter int unsigned IW  = 2,
   parameter int unsigned IDX = 0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 a_vld,
   input  logic signed [AW-1:0] a_dat,
   input  logic                 ld_vld,
   input  logic [IW-1:0]        ld_sel,
   input  logic signed [WW-1:0] ld_dat,
   input  logic signed [SW-1:0] ps_in,
   output logic signed [SW-1:0] ps_out
);

   localparam int unsigned PW = AW + WW;

   if (SW < PW) begin : g_bad_sum
      $error("mac_pe: SW narrower than the product");
   end

   logic signed [WW-1:0] w_q;
   logic signed [PW-1:0] prod;
   logic signed [SW-1:0] ps_q;
   logic                 hit;

   assign hit  = ld_vld && (ld_sel == IW'(IDX));
   assign prod = a_dat * w_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q  <= '0;
         ps_q <= '0;
      end else begin
         if (hit) w_q <= ld_dat;
         // Bubbles leave a zero behind so idle outputs read zero.
         ps_q <= a_vld ? (ps_in + SW'(prod)) : '0;
      end
   end

   assign ps_out = ps_q;

   // R8: a coefficient only changes on a write addressed to this cell.
   p_weight_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !hit |=> $stable(w_q))
      else $error("p_weight_hold_r8: coefficient changed without a write");

endmodule

// File: rtl/mac_grid.sv
// Weight-stationary systolic grid with internal input skew and output realignment.
module mac_grid
   import mac_grid_pkg::*;
#(
   parameter int unsigned ROWS = 2,
   parameter int unsigned COLS = 2,
   parameter int unsigned AW   = 8,
   parameter int unsigned WW   = 8,
   parameter int unsigned SW   = 32,
   localparam int unsigned SELW = idx_bits(ROWS * COLS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wt_load,
   input  logic [SELW-1:0]      wt_sel,
   input  logic [WW-1:0]        wt_data,
   input  logic                 in_valid,
   input  logic [ROWS*AW-1:0]   in_act,
   output logic                 busy,
   output logic                 out_valid,
   output logic [COLS*SW-1:0]   out_sum
);

   localparam int unsigned LAT = ROWS + COLS - 2;   // edges from accept to last cell
   localparam int unsigned CW  = idx_bits(LAT + 1);
   localparam int unsigned AVW = AW + 1;            // activation plus valid bit
   localparam int unsigned LDW = 1 + SELW + WW;     // write valid, index, value

   if (ROWS < 1 || COLS < 1) begin : g_bad_dims
      $error("mac_grid: ROWS and COLS must be at least 1");
   end
   if (SW < AW + WW + idx_bits(ROWS)) begin : g_bad_sw
      $error("mac_grid: SW too narrow for the column sum");
   end

   // ---------------------------------------------------------------
   // In-flight counter and write acceptance
   // ---------------------------------------------------------------
   logic [CW-1:0] fly_cnt;
   logic          ld_take;

   always_ff @(posedge clk) begin
      if (rst)                fly_cnt <= '0;
      else if (in_valid)      fly_cnt <= CW'(LAT);
      else if (fly_cnt != '0) fly_cnt <= fly_cnt - 1'b1;
   end

   assign busy    = (fly_cnt != '0);
   assign ld_take = wt_load && !busy && !in_valid;

   // ---------------------------------------------------------------
   // Grid fabric
   // ---------------------------------------------------------------
   logic [AVW-1:0] act_bus [ROWS][COLS];
   logic [LDW-1:0] ld_bus  [ROWS][COLS];
   logic [SW-1:0]  ps_top  [ROWS][COLS];
   logic [SW-1:0]  psum    [ROWS][COLS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col

         // Activation path: row skew at the left edge, one hop per column.
         if (c == 0) begin : g_act_edge
            if (r == 0) begin : g_act_direct
               assign act_bus[r][c] = {in_valid, in_act[0 +: AW]};
            end else begin : g_act_skew
               mac_skew #(.WIDTH(AVW), .DEPTH(r)) u_skew (
                  .clk (clk),
                  .rst (rst),
                  .d   ({in_valid, in_act[r*AW +: AW]}),
                  .q   (act_bus[r][c])
               );
            end
         end else begin : g_act_hop
            mac_skew #(.WIDTH(AVW), .DEPTH(1)) u_hop (
               .clk (clk),
               .rst (rst),
               .d   (act_bus[r][c-1]),
               .q   (act_bus[r][c])
            );
         end

         // Coefficient write path: right along rows, down the first column.
         if (c == 0 && r == 0) begin : g_ld_entry
            assign ld_bus[r][c] = {ld_take, wt_sel, wt_data};
         end else if (c == 0) begin : g_ld_down
            mac_skew #(.WIDTH(LDW), .DEPTH(1)) u_ld (
               .clk (clk),
               .rst (rst),
               .d   (ld_bus[r-1][c]),
               .q   (ld_bus[r][c])
            );
         end else begin : g_ld_right
            mac_skew #(.WIDTH(LDW), .DEPTH(1)) u_ld (
               .clk (clk),
               .rst (rst),
               .d   (ld_bus[r][c-1]),
               .q   (ld_bus[r][c])
            );
         end

         // Partial-sum entry.
         if (r == 0) begin : g_ps_zero
            assign ps_top[r][c] = '0;
         end else begin : g_ps_chain
            assign ps_top[r][c] = psum[r-1][c];
         end

         mac_pe #(
            .AW  (AW),
            .WW  (WW),
            .SW  (SW),
            .IW  (SELW),
            .IDX (r * COLS + c)
         ) u_pe (
            .clk    (clk),
            .rst    (rst),
            .a_vld  (act_bus[r][c][AW]),
            .a_dat  (act_bus[r][c][AW-1:0]),
            .ld_vld (ld_bus[r][c][LDW-1]),
            .ld_sel (ld_bus[r][c][WW +: SELW]),
            .ld_dat (ld_bus[r][c][WW-1:0]),
            .ps_in  (ps_top[r][c]),
            .ps_out (psum[r][c])
         );
      end
   end

   // ---------------------------------------------------------------
   // Output realignment: column c waits COLS-1-c extra cycles
   // ---------------------------------------------------------------
   for (genvar c = 0; c < COLS; c++) begin : g_out
      if (c == COLS - 1) begin : g_out_direct
         assign out_sum[c*SW +: SW] = psum[ROWS-1][c];
      end else begin : g_out_delay
         mac_skew #(.WIDTH(SW), .DEPTH(COLS - 1 - c)) u_deskew (
            .clk (clk),
            .rst (rst),
            .d   (psum[ROWS-1][c]),
            .q   (out_sum[c*SW +: SW])
         );
      end
   end

   mac_skew #(.WIDTH(1), .DEPTH(1)) u_out_vld (
      .clk (clk),
      .rst (rst),
      .d   (act_bus[ROWS-1][COLS-1][AW]),
      .q   (out_valid)
   );

   // ---------------------------------------------------------------
   // Assertions
   // ---------------------------------------------------------------
   // R9: results only follow an offered vector or an in-flight one.
   p_out_needs_input_r9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($past(busy) || $past(in_valid)))
      else $error("p_out_needs_input_r9: result without a vector in flight");

   // R7: the in-flight window closes exactly when the last result emerges.
   p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> out_valid)
      else $error("p_busy_end_r7: busy dropped without a result");

   // R7: busy only starts because a vector was offered.
   p_busy_rise_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(in_valid))
      else $error("p_busy_rise_r7: busy rose with no vector");

   // R7: an offered vector keeps the grid busy in the next cycle.
   p_busy_follows_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (LAT > 0)) |=> busy)
      else $error("p_busy_follows_r7: busy missing after a vector");

endmodule

// File: tb/sim_mac_grid.sv
`timescale 1ns/1ps
module sim_mac_grid;

   localparam int R  = 2;
   localparam int C  = 2;
   localparam int AW = 8;
   localparam int WW = 8;
   localparam int SW = 32;
   localparam int OUT_LAG = R + C - 1;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              wt_load = 1'b0;
   logic [1:0]        wt_sel = '0;
   logic [WW-1:0]     wt_data = '0;
   logic              in_valid = 1'b0;
   logic [R*AW-1:0]   in_act = '0;
   logic              busy;
   logic              out_valid;
   logic [C*SW-1:0]   out_sum;

   always #2 clk = ~clk;

   mac_grid u0 (
      .clk       (clk),
      .rst       (rst),
      .wt_load   (wt_load),
      .wt_sel    (wt_sel),
      .wt_data   (wt_data),
      .in_valid  (in_valid),
      .in_act    (in_act),
      .busy      (busy),
      .out_valid (out_valid),
      .out_sum   (out_sum)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;
   bit mon_en = 1'b0;
   int wm [R][C];

   typedef struct {
      int              due;
      logic [C*SW-1:0] sum;
      string           req;
   } exp_t;
   exp_t expq [$];

   always @(posedge clk) cyc++;

   task automatic fail(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
   endtask

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) fail(req, what, act, exp);
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // Output monitor: timing, values and quiet idle outputs (R3, R4, R5, R9).
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (mon_en) begin
            if (out_valid) begin
               checks++;
               if (expq.size() == 0) begin
                  fail("R9", "unexpected out_valid", 64'(out_valid), 64'd0);
               end else begin
                  exp_t e;
                  e = expq.pop_front();
                  if (e.due != cyc) fail("R4", "result cycle", 64'(cyc), 64'(e.due));
                  if (out_sum !== e.sum) fail(e.req, "column sums", out_sum, e.sum);
               end
            end else begin
               checks++;
               if (out_sum !== '0) fail("R9", "idle out_sum not zero", out_sum, 64'd0);
               if (expq.size() > 0 && expq[0].due <= cyc) begin
                  fail("R4", "missing result", 64'(cyc), 64'(expq[0].due));
                  void'(expq.pop_front());
               end
            end
         end
      end
   end

   // Offer one vector in the current cycle; model the expected result.
   task automatic send(input int a0, input int a1, input string req);
      exp_t e;
      int   av [R];
      av[0] = a0;
      av[1] = a1;
      e.due = cyc + OUT_LAG;
      e.req = req;
      e.sum = '0;
      for (int c = 0; c < C; c++) begin
         int s;
         s = 0;
         for (int r = 0; r < R; r++) s += av[r] * wm[r][c];
         e.sum[c*SW +: SW] = s;
      end
      expq.push_back(e);
      in_valid = 1'b1;
      in_act   = {a1[AW-1:0], a0[AW-1:0]};
      tick();
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      in_act   = '0;
      for (int i = 0; i < n; i++) tick();
   endtask

   // Write strobe in the current cycle; taken says whether it should land.
   task automatic load(input int sel, input int val, input bit taken);
      wt_load = 1'b1;
      wt_sel  = sel[1:0];
      wt_data = val[WW-1:0];
      if (taken) wm[sel / C][sel % C] = val;
      tick();
      wt_load = 1'b0;
   endtask

   task automatic t_reset();
      // R1: outputs after reset, coefficients start at zero.
      check("R1", "busy after reset", 64'(busy), 64'd0);
      check("R1", "out_valid after reset", 64'(out_valid), 64'd0);
      check("R1", "out_sum after reset", out_sum, 64'd0);
      send(5, -3, "R1");
      send(-128, 127, "R1");
      idle(6);
   endtask

   task automatic t_wave();
      // R2: ascending writes, vector in the very next cycle.
      load(0, 3, 1'b1);
      load(1, -2, 1'b1);
      load(2, 7, 1'b1);
      load(3, 5, 1'b1);
      send(4, -6, "R2");
      send(1, 1, "R2");
      idle(6);
      // R2: descending writes, cell (0,0) written last.
      load(3, -9, 1'b1);
      load(2, 11, 1'b1);
      load(1, 13, 1'b1);
      load(0, -17, 1'b1);
      send(-2, 3, "R2");
      send(100, -100, "R3");
      idle(6);
   endtask

   task automatic t_busy();
      // R7 and R4: exact busy window and single-cycle result pulse.
      send(2, 2, "R4");
      check("R7", "busy at t+1", 64'(busy), 64'd1);
      check("R4", "out_valid at t+1", 64'(out_valid), 64'd0);
      idle(1);
      check("R7", "busy at t+2", 64'(busy), 64'd1);
      check("R4", "out_valid at t+2", 64'(out_valid), 64'd0);
      idle(1);
      check("R7", "busy at t+3", 64'(busy), 64'd0);
      check("R4", "out_valid at t+3", 64'(out_valid), 64'd1);
      idle(1);
      check("R4", "out_valid at t+4", 64'(out_valid), 64'd0);
      idle(3);
   endtask

   task automatic t_stream();
      // R5 and R3: extreme coefficients, back-to-back vectors.
      load(0, -128, 1'b1);
      load(1, 127, 1'b1);
      load(2, -128, 1'b1);
      load(3, -128, 1'b1);
      send(-128, -128, "R3");
      send(127, -128, "R3");
      send(127, 127, "R3");
      for (int i = 0; i < 10; i++) begin
         int x0;
         int x1;
         x0 = int'($signed(8'($urandom())));
         x1 = int'($signed(8'($urandom())));
         send(x0, x1, "R5");
      end
      idle(6);
   endtask

   task automatic t_ignore();
      // R6: writes colliding with in_valid or arriving while busy.
      load(0, 6, 1'b1);
      load(1, -4, 1'b1);
      load(2, 8, 1'b1);
      load(3, 9, 1'b1);
      send(1, 2, "R6");
      wt_load = 1'b1;
      wt_sel  = 2'd0;
      wt_data = 8'd99;
      send(3, -5, "R6");
      wt_load = 1'b0;
      in_valid = 1'b0;
      in_act   = '0;
      check("R6", "busy during refused write", 64'(busy), 64'd1);
      load(1, 55, 1'b0);
      idle(5);
      send(10, 20, "R6");
      send(-7, 3, "R6");
      idle(6);
   endtask

   task automatic t_persist();
      // R8: retention across idle time; single-cell rewrite.
      idle(20);
      send(12, -11, "R8");
      idle(5);
      load(2, -33, 1'b1);
      send(12, -11, "R8");
      send(-1, 2, "R8");
      idle(6);
   endtask

   task automatic t_gaps();
      // R9: scattered vectors with idle gaps, no stray results.
      send(3, 4, "R9");
      idle(1);
      send(-3, 4, "R9");
      idle(2);
      send(5, 0, "R9");
      idle(4);
      send(0, -6, "R9");
      idle(8);
      check("R4", "results outstanding", 64'(expq.size()), 64'd0);
   endtask

   initial begin
      for (int r = 0; r < R; r++)
         for (int c = 0; c < C; c++) wm[r][c] = 0;
      rst = 1'b1;
      repeat (4) tick();
      rst = 1'b0;
      mon_en = 1'b1;
      t_reset();
      t_wave();
      t_busy();
      t_stream();
      t_ignore();
      t_persist();
      t_gaps();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule